// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block is the front end of a single DMA channel that walks a ring of descriptors in host memory. It keeps a current-descriptor pointer, reads the first word of the descriptor at that pointer over a one-word read request/response port, and inspects the ownership bit. A descriptor owned by the DMA goes to a downstream data engine together with its address. When the engine reports completion, the controller writes the first word back with ownership returned to the host, moves the pointer on, and fetches the next descriptor without waiting for software.

The distance from one descriptor to the next is set by software. It is the descriptor size, 16 bytes in the normal format or 32 bytes in the enhanced format, plus a programmable number of 4-byte words skipped after each descriptor. A skip of zero gives a packed table. An end-of-ring bit in a descriptor sends the pointer back to the programmed base address.

The channel suspends when it reads a host-owned descriptor or when the engine reports an underflow. It leaves suspend only after a poll demand, which makes it re-read the descriptor at the current pointer. Status outputs give the suspend state, a pending poll, a buffer-unavailable flag and an underflow flag.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset the channel is suspended, `cur_ptr` is 0, none of `rd_req_valid`, `desc_valid` or `wr_valid` is high, and all status flags are 0.
- R2: A write on the base-address port while suspended loads both the base address and `cur_ptr`. While the channel is active the write is ignored, so neither the pointer nor a later ring wrap is affected.
- R3: A `poll_demand` pulse while suspended makes the channel issue a read at `cur_ptr`. `st_poll_pending` is set by the pulse and clears when a read request is accepted. An unaccepted request holds its address.
- R4: When bit 31 of the first descriptor word is 1 (DMA-owned), the channel presents `desc_addr` equal to the descriptor address and `desc_word0` equal to the word it read.
- R5: When bit 31 of the word read is 0 (host-owned), nothing is handed to the engine, the channel suspends and `st_buf_unavail` is set. A further poll while the descriptor stays host-owned has the same result.
- R6: On `eng_done`, the channel writes to the descriptor address the first word with bit 31 cleared. It then issues the next read without a poll.
- R7: The next descriptor address is the current address plus 16 (`cfg_enh_fmt`=0) or 32 (`cfg_enh_fmt`=1), plus 4 times `cfg_skip_words`. A skip of 0 gives a packed table.
- R8: When bit 21 of the first descriptor word is set, the address after that descriptor is the programmed base address.
- R9: `eng_underflow` while the engine holds a descriptor suspends the channel with no write-back, leaves `cur_ptr` unchanged and sets `st_underflow`. The next poll re-reads the same descriptor.
- R10: Reading a DMA-owned descriptor clears both `st_buf_unavail` and `st_underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Base-address write strobe |
| cfg_base_wdata | input | AW | Ring base address |
| cfg_enh_fmt | input | 1 | 1 selects 32-byte descriptors, 0 selects 16-byte descriptors |
| cfg_skip_words | input | SKIP_W | Words skipped between descriptors |
| poll_demand | input | 1 | One-cycle poll request |
| rd_req_valid | output | 1 | Descriptor word read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| desc_valid | output | 1 | Descriptor offered to the engine |
| desc_ready | input | 1 | Engine takes the descriptor |
| desc_addr | output | AW | Address of the offered descriptor |
| desc_word0 | output | 32 | First word of the offered descriptor |
| eng_done | input | 1 | Engine finished the descriptor |
| eng_underflow | input | 1 | Engine aborted on underflow |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | AW | Write-back address |
| wr_data | output | 32 | First word with ownership cleared |
| cur_ptr | output | AW | Current descriptor pointer |
| st_suspended | output | 1 | Channel is suspended |
| st_poll_pending | output | 1 | Poll demand not yet acted on |
| st_buf_unavail | output | 1 | Last descriptor read was host-owned |
| st_underflow | output | 1 | Engine reported underflow |

## Verification
The assertions assume a one-word read port: exactly one `rd_rsp_valid` pulse follows each accepted request, and nothing arrives otherwise. They also assume the engine raises `eng_done` or `eng_underflow` only while it holds a descriptor. The bench models memory and engine to respect both: it returns read data one cycle after acceptance and pulses completion one cycle after hand-off. Ready inputs are tied high, so every request is accepted in the cycle it appears.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned EOR_BIT    = 21;
  localparam int unsigned NORM_BYTES = 16;
  localparam int unsigned ENH_BYTES  = 32;

  typedef enum logic [2:0] {
    ST_SUSP   = 3'd0,
    ST_RDREQ  = 3'd1,
    ST_RDWAIT = 3'd2,
    ST_HAND   = 3'd3,
    ST_BUSY   = 3'd4,
    ST_WB     = 3'd5
  } dring_state_e;
endpackage

// File: rtl/dring_next_addr.sv
module dring_next_addr
  import dring_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SKIP_W = 5
) (
  input  logic [AW-1:0]     cur_ptr,
  input  logic [AW-1:0]     base_addr,
  input  logic              enh_fmt,
  input  logic [SKIP_W-1:0] skip_words,
  input  logic              wrap,
  output logic [AW-1:0]     next_ptr
);
  logic [AW-1:0] desc_bytes;
  logic [AW-1:0] gap_bytes;

  always_comb begin
    desc_bytes = enh_fmt ? AW'(ENH_BYTES) : AW'(NORM_BYTES);
    gap_bytes  = AW'({skip_words, 2'b00});
    next_ptr   = wrap ? base_addr : (cur_ptr + desc_bytes + gap_bytes);
  end
endmodule

// File: rtl/dring_flags.sv
module dring_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_demand,
  input  logic rd_accept,
  input  logic rsp_owned_evt,
  input  logic rsp_host_evt,
  input  logic underflow_evt,
  output logic poll_pend_q,
  output logic buf_unavail_q,
  output logic underflow_q
);
  logic poll_pend_d, buf_unavail_d, underflow_d;

  always_comb begin
    poll_pend_d = poll_demand | (poll_pend_q & ~rd_accept);

    buf_unavail_d = buf_unavail_q;
    if (rsp_host_evt)       buf_unavail_d = 1'b1;
    else if (rsp_owned_evt) buf_unavail_d = 1'b0;

    underflow_d = underflow_q;
    if (underflow_evt)      underflow_d = 1'b1;
    else if (rsp_owned_evt) underflow_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_pend_q   <= 1'b0;
      buf_unavail_q <= 1'b0;
      underflow_q   <= 1'b0;
    end else begin
      poll_pend_q   <= poll_pend_d;
      buf_unavail_q <= buf_unavail_d;
      underflow_q   <= underflow_d;
    end
  end
endmodule

// File: rtl/dring_fsm.sv
module dring_fsm
  import dring_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         poll_pend,
  input  logic         rd_req_ready,
  input  logic         rd_rsp_valid,
  input  logic         rsp_owned,
  input  logic         desc_ready,
  input  logic         eng_done,
  input  logic         eng_underflow,
  input  logic         wr_ready,
  output dring_state_e state_q
);
  dring_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SUSP:   if (poll_pend)    state_d = ST_RDREQ;
      ST_RDREQ:  if (rd_req_ready) state_d = ST_RDWAIT;
      ST_RDWAIT: if (rd_rsp_valid) state_d = rsp_owned ? ST_HAND : ST_SUSP;
      ST_HAND:   if (desc_ready)   state_d = ST_BUSY;
      ST_BUSY: begin
        if (eng_underflow)  state_d = ST_SUSP;
        else if (eng_done)  state_d = ST_WB;
      end
      ST_WB:     if (wr_ready)     state_d = ST_RDREQ;
      default:                     state_d = ST_SUSP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SUSP;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import dring_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_base_we,
  input  logic [AW-1:0]     cfg_base_wdata,
  input  logic              cfg_enh_fmt,
  input  logic [SKIP_W-1:0] cfg_skip_words,
  input  logic              poll_demand,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [AW-1:0]     desc_addr,
  output logic [WORD_W-1:0] desc_word0,
  input  logic              eng_done,
  input  logic              eng_underflow,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [AW-1:0]     cur_ptr,
  output logic              st_suspended,
  output logic              st_poll_pending,
  output logic              st_buf_unavail,
  output logic              st_underflow
);
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

  dring_state_e      state_q;
  logic [AW-1:0]     base_q, base_d;
  logic [AW-1:0]     ptr_q, ptr_d, ptr_next;
  logic [WORD_W-1:0] word0_q, word0_d;
  logic              cfg_load, rd_accept, rsp_take, rsp_owned;
  logic              advance, in_busy, poll_pend;

  // event decode
  always_comb begin
    in_busy   = (state_q == ST_BUSY);
    cfg_load  = cfg_base_we && (state_q == ST_SUSP);
    rd_accept = rd_req_valid && rd_req_ready;
    rsp_take  = (state_q == ST_RDWAIT) && rd_rsp_valid;
    rsp_owned = rd_rsp_data[OWN_BIT];
    advance   = (state_q == ST_WB) && wr_ready;
  end

  dring_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .poll_pend     (poll_pend),
    .rd_req_ready  (rd_req_ready),
    .rd_rsp_valid  (rd_rsp_valid),
    .rsp_owned     (rsp_owned),
    .desc_ready    (desc_ready),
    .eng_done      (eng_done),
    .eng_underflow (eng_underflow),
    .wr_ready      (wr_ready),
    .state_q       (state_q)
  );

  dring_next_addr #(.AW(AW), .SKIP_W(SKIP_W)) u_next (
    .cur_ptr    (ptr_q),
    .base_addr  (base_q),
    .enh_fmt    (cfg_enh_fmt),
    .skip_words (cfg_skip_words),
    .wrap       (word0_q[EOR_BIT]),
    .next_ptr   (ptr_next)
  );

  dring_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .poll_demand   (poll_demand),
    .rd_accept     (rd_accept),
    .rsp_owned_evt (rsp_take && rsp_owned),
    .rsp_host_evt  (rsp_take && !rsp_owned),
    .underflow_evt (in_busy && eng_underflow),
    .poll_pend_q   (poll_pend),
    .buf_unavail_q (st_buf_unavail),
    .underflow_q   (st_underflow)
  );

  // pointer, base and captured word: next-state
  always_comb begin
    base_d  = base_q;
    ptr_d   = ptr_q;
    word0_d = word0_q;
    if (cfg_load) begin
      base_d = cfg_base_wdata;
      ptr_d  = cfg_base_wdata;
    end else if (advance) begin
      ptr_d  = ptr_next;
    end
    if (rsp_take && rsp_owned) word0_d = rd_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      ptr_q   <= '0;
      word0_q <= '0;
    end else begin
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      word0_q <= word0_d;
    end
  end

  // outputs
  always_comb begin
    rd_req_valid    = (state_q == ST_RDREQ);
    rd_req_addr     = ptr_q;
    desc_valid      = (state_q == ST_HAND);
    desc_addr       = ptr_q;
    desc_word0      = word0_q;
    wr_valid        = (state_q == ST_WB);
    wr_addr         = ptr_q;
    wr_data         = word0_q & ~OWN_MASK;
    cur_ptr         = ptr_q;
    st_suspended    = (state_q == ST_SUSP);
    st_poll_pending = poll_pend;
  end
endmodule

// File: rtl/dring_checker.sv
module dring_checker
  import dring_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input dring_state_e      state,
  input logic              poll_demand,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [AW-1:0]     rd_req_addr,
  input logic              rd_rsp_valid,
  input logic [WORD_W-1:0] rd_rsp_data,
  input logic              desc_valid,
  input logic [WORD_W-1:0] desc_word0,
  input logic              eng_underflow,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [WORD_W-1:0] wr_data,
  input logic [AW-1:0]     cur_ptr,
  input logic              st_suspended,
  input logic              st_poll_pending,
  input logic              st_buf_unavail,
  input logic              st_underflow
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R3

  AST_POLL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready && !poll_demand |=> !st_poll_pending); // R3

  AST_HAND_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_word0[OWN_BIT]); // R4

  AST_HOST_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDWAIT) && rd_rsp_valid && !rd_rsp_data[OWN_BIT]
      |=> st_suspended && st_buf_unavail); // R5

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wr_data[OWN_BIT]); // R6

  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> rd_req_valid); // R6

  AST_UNF_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) && eng_underflow
      |=> st_suspended && st_underflow && $stable(cur_ptr)); // R9
endmodule

bind desc_ring_fetch dring_checker #(.AW(AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .state           (state_q),
  .poll_demand     (poll_demand),
  .rd_req_valid    (rd_req_valid),
  .rd_req_ready    (rd_req_ready),
  .rd_req_addr     (rd_req_addr),
  .rd_rsp_valid    (rd_rsp_valid),
  .rd_rsp_data     (rd_rsp_data),
  .desc_valid      (desc_valid),
  .desc_word0      (desc_word0),
  .eng_underflow   (eng_underflow),
  .wr_valid        (wr_valid),
  .wr_ready        (wr_ready),
  .wr_data         (wr_data),
  .cur_ptr         (cur_ptr),
  .st_suspended    (st_suspended),
  .st_poll_pending (st_poll_pending),
  .st_buf_unavail  (st_buf_unavail),
  .st_underflow    (st_underflow)
);

// File: tb/tb_desc_ring_fetch.sv
module tb_desc_ring_fetch;
  localparam int AW = 32;
  localparam int SW = 5;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h0020_0000;

  logic          clk, rst_n;
  logic          cfg_base_we, cfg_enh_fmt, poll_demand;
  logic [AW-1:0] cfg_base_wdata;
  logic [SW-1:0] cfg_skip_words;
  logic          rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [AW-1:0] rd_req_addr;
  logic [31:0]   rd_rsp_data;
  logic          desc_valid, desc_ready, eng_done, eng_underflow;
  logic [AW-1:0] desc_addr;
  logic [31:0]   desc_word0;
  logic          wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [AW-1:0] cur_ptr;
  logic          st_suspended, st_poll_pending, st_buf_unavail, st_underflow;

  desc_ring_fetch #(.AW(AW), .SKIP_W(SW)) dut (.*);

  // responder-owned state
  logic [31:0] mem [512];
  logic [31:0] rd_log [256];
  logic [31:0] hd_addr [256];
  logic [31:0] hd_word [256];
  logic [31:0] wb_addr [256];
  logic [31:0] wb_data [256];
  int n_rd, n_hd, n_wb, ld_seen;
  // main-owned state
  int ld_seq;
  logic [31:0] ld_addr, ld_data;
  logic unf_mode;
  int n_chk, n_fail;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // memory, engine and monitor model
  initial begin
    logic rpend, efire;
    logic [31:0] raddr;
    rpend = 1'b0; efire = 1'b0; raddr = '0;
    rd_rsp_valid = 1'b0; rd_rsp_data = '0; eng_done = 1'b0; eng_underflow = 1'b0;
    rd_req_ready = 1'b1; desc_ready = 1'b1; wr_ready = 1'b1;
    n_rd = 0; n_hd = 0; n_wb = 0; ld_seen = 0;
    for (int k = 0; k < 512; k++) mem[k] = 32'h0BAD_0000 | k;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0; eng_done = 1'b0; eng_underflow = 1'b0;
      if (ld_seq != ld_seen) begin mem[ld_addr[10:2]] = ld_data; ld_seen = ld_seq; end
      if (rpend) begin rd_rsp_valid = 1'b1; rd_rsp_data = mem[raddr[10:2]]; rpend = 1'b0; end
      if (efire) begin
        if (unf_mode) eng_underflow = 1'b1; else eng_done = 1'b1;
        efire = 1'b0;
      end
      if (rst_n) begin
        if (rd_req_valid) begin rpend = 1'b1; raddr = rd_req_addr; rd_log[n_rd[7:0]] = rd_req_addr; n_rd++; end
        if (desc_valid) begin hd_addr[n_hd[7:0]] = desc_addr; hd_word[n_hd[7:0]] = desc_word0; n_hd++; efire = 1'b1; end
        if (wr_valid) begin wb_addr[n_wb[7:0]] = wr_addr; wb_data[n_wb[7:0]] = wr_data; n_wb++; mem[wr_addr[10:2]] = wr_data; end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
    $finish;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
    ld_addr = a; ld_data = d; ld_seq++;
    tick();
  endtask

  task automatic base_write(input logic [31:0] a);
    cfg_base_we = 1'b1; cfg_base_wdata = a;
    tick();
    cfg_base_we = 1'b0;
  endtask

  task automatic poll();
    poll_demand = 1'b1;
    tick();
    poll_demand = 1'b0;
    tick();
  endtask

  task automatic wait_susp();
    while (!st_suspended) tick();
  endtask

  task automatic run_cfg(input logic enh, input int skip, input int tag);
    logic [31:0] b, step, w;
    int h0, w0, r0;
    b = 32'h40;
    step = (enh ? 32'd32 : 32'd16) + 32'(4 * skip);
    cfg_enh_fmt = enh; cfg_skip_words = SW'(skip);
    for (int i = 0; i < 3; i++) begin
      w = OWN | 32'(tag << 8) | 32'(i) | ((i == 2) ? EOR : 32'h0);
      mem_put(b + 32'(i) * step, w);
    end
    base_write(b);
    chk("R2 base load sets pointer", cur_ptr, b);
    h0 = n_hd; w0 = n_wb; r0 = n_rd;
    poll_demand = 1'b1; tick(); poll_demand = 1'b0;
    chk("R3 poll pending set", 32'(st_poll_pending), 32'd1);
    while (n_hd == h0) tick();
    base_write(32'h300);   // active: must be ignored
    while (!(st_suspended && n_wb == w0 + 3)) tick();
    chk("R3 first read at pointer", rd_log[r0[7:0]], b);
    chk("R3 poll pending cleared", 32'(st_poll_pending), 32'd0);
    chk("R4 hand-offs", 32'(n_hd - h0), 32'd3);
    for (int i = 0; i < 3; i++) begin
      w = OWN | 32'(tag << 8) | 32'(i) | ((i == 2) ? EOR : 32'h0);
      chk("R7 descriptor address", hd_addr[(h0 + i) % 256], b + 32'(i) * step);
      chk("R4 descriptor word", hd_word[(h0 + i) % 256], w);
      chk("R6 write-back address", wb_addr[(w0 + i) % 256], b + 32'(i) * step);
      chk("R6 write-back data", wb_data[(w0 + i) % 256], w & ~OWN);
    end
    chk("R6 fetch after write-back without poll", 32'(n_rd - r0), 32'd4);
    chk("R8 wrap read at base", rd_log[(r0 + 3) % 256], b);
    chk("R2 ignored base write, R8 pointer at base", cur_ptr, b);
    chk("R5 buffer unavailable", 32'(st_buf_unavail), 32'd1);

    // host-owned re-poll
    h0 = n_hd;
    poll(); wait_susp(); repeat (3) tick();
    chk("R5 no hand-off on host-owned", 32'(n_hd - h0), 32'd0);
    chk("R5 still suspended", 32'(st_suspended), 32'd1);
    chk("R5 flag after re-poll", 32'(st_buf_unavail), 32'd1);

    // underflow
    mem_put(b, OWN | 32'h55);
    unf_mode = 1'b1; h0 = n_hd; w0 = n_wb;
    poll(); wait_susp();
    chk("R9 hand-off before underflow", hd_addr[h0 % 256], b);
    chk("R9 underflow flag", 32'(st_underflow), 32'd1);
    chk("R9 no write-back", 32'(n_wb - w0), 32'd0);
    chk("R9 pointer unchanged", cur_ptr, b);
    chk("R10 unavailable cleared by owned read", 32'(st_buf_unavail), 32'd0);
    unf_mode = 1'b0;
    poll(); wait_susp();
    chk("R9 same descriptor re-read", hd_addr[(h0 + 1) % 256], b);
    chk("R9 hand-off count after resume", 32'(n_hd - h0), 32'd2);
    chk("R10 underflow cleared", 32'(st_underflow), 32'd0);
    chk("R7 pointer advanced", cur_ptr, b + step);
    chk("R5 next was host-owned", 32'(st_buf_unavail), 32'd1);
  endtask

  initial begin
    int skips [6];
    skips = '{0, 1, 2, 3, 7, 31};
    n_chk = 0; n_fail = 0; ld_seq = 0; ld_addr = '0; ld_data = '0; unf_mode = 1'b0;
    rst_n = 1'b0; cfg_base_we = 1'b0; cfg_base_wdata = '0;
    cfg_enh_fmt = 1'b0; cfg_skip_words = '0; poll_demand = 1'b0;
    repeat (3) tick();
    chk("R1 suspended in reset", 32'(st_suspended), 32'd1);
    rst_n = 1'b1;
    repeat (2) tick();
    chk("R1 suspended", 32'(st_suspended), 32'd1);
    chk("R1 pointer", cur_ptr, 32'd0);
    chk("R1 no requests", {29'd0, rd_req_valid, desc_valid, wr_valid}, 32'd0);
    chk("R1 flags", {29'd0, st_poll_pending, st_buf_unavail, st_underflow}, 32'd0);
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 6; s++)
        run_cfg(e[0], skips[s], e * 6 + s + 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule